// File: doc/BRIEF.md
# I/O Window Address Translator

This bridge claims CPU accesses that land in an 8 MB window starting at CPU address 0x8000_0000. It turns each one into a single cycle on a 16-bit I/O port bus, keeping the access's size, direction and write data. It then hands the read data back to the CPU.

A map-mode input chooses how the window offset becomes a port address. In contiguous mode the window behaves as a flat 64 KB port space. In sparse mode, each 4 KB page of the window exposes 32 ports: the low five offset bits choose the port within the page, and offset bits 12 to 22 go into port address bits 5 to 15.

Data passes through in little-endian order with no lane swapping. Accesses outside the window are left for other targets. The bridge serves one access at a time.

Top module: `iowin_xlate`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `port_req` and `cpu_ack` are both low.
- R2: A one-cycle `cpu_req` strobe whose address lies in [0x8000_0000, 0x8080_0000) raises `port_req` in the next cycle.
- R3: A strobe whose address lies outside that range starts no port cycle and produces no `cpu_ack`.
- R4: With `map_sparse` = 0 at the strobe, `port_addr` equals address bits 15:0.
- R5: With `map_sparse` = 1 at the strobe, `port_addr` equals (offset AND 0x1F) OR ((offset AND 0x007F_F000) >> 7), that is {addr[22:12], addr[4:0]}.
- R6: `port_size` (0 byte, 1 halfword, 2 word), `port_we` and `port_wdata` equal the values given with the strobe.
- R7: While `port_req` is high and `port_ack` is low, `port_req`, `port_addr`, `port_size`, `port_we` and `port_wdata` stay unchanged.
- R8: `port_ack` sampled high ends the port cycle. In the next cycle `cpu_ack` is high for exactly one cycle and `port_req` is low. For reads, `cpu_rdata` then equals `port_rdata` as it was when acknowledged, unswapped.
- R9: A change of `map_sparse` after the strobe does not alter the port address of the access in progress.
- R10: A `cpu_req` strobe arriving while an access is in progress is ignored. It changes no held port field and starts no port cycle after the current one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_sparse | input | 1 | Map mode: 0 contiguous, 1 sparse; sampled at the strobe |
| cpu_req | input | 1 | One-cycle access strobe from the CPU side |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| cpu_addr | input | 32 | CPU byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` for reads |
| port_req | output | 1 | Port cycle request, held until acknowledged |
| port_we | output | 1 | Port cycle direction |
| port_size | output | 2 | Port cycle size |
| port_addr | output | 16 | Translated port address |
| port_wdata | output | 32 | Port write data |
| port_ack | input | 1 | Port cycle acknowledge |
| port_rdata | input | 32 | Port read data, valid with `port_ack` |

## Verification
A corrupted controller state shows up within one cycle. It appears as a `port_req` that starts without a strobe or never drops, or as a `cpu_ack` that is missing, lasts too long, or has no preceding port acknowledge. A wrong held field is visible on `port_addr`, `port_size`, `port_we` or `port_wdata` from the first cycle of the port cycle. The bench deliberately flips the mode, strobes new addresses and changes the write data during that cycle, so a held field that is not really held changes while the bench is watching it. A capture fault on the read path appears on `cpu_rdata` in the acknowledge cycle, because the bench replaces the port data right after the acknowledge.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

  // controller phases of one bridged access
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_RESP  = 2'd2
  } iowin_state_e;

  // access size encoding shared by both sides
  localparam int unsigned SIZE_W = 2;
  localparam logic [SIZE_W-1:0] SZ_BYTE = 2'd0;
  localparam logic [SIZE_W-1:0] SZ_HALF = 2'd1;
  localparam logic [SIZE_W-1:0] SZ_WORD = 2'd2;

endpackage

// File: rtl/iowin_decode.sv
module iowin_decode #(
  parameter int unsigned       ADDR_W        = 32,
  parameter int unsigned       PORT_W        = 16,
  parameter int unsigned       WIN_LOG2      = 23,
  parameter logic [ADDR_W-1:0] WIN_BASE      = 32'h8000_0000,
  parameter int unsigned       SPARSE_LO_W   = 5,
  parameter int unsigned       SPARSE_HI_LSB = 12,
  parameter bit                SPARSE_EN     = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              sparse,
  output logic              hit,
  output logic [PORT_W-1:0] xaddr
);

  localparam int unsigned SPARSE_HI_W = PORT_W - SPARSE_LO_W;

  logic [PORT_W-1:0] contig_addr;
  logic [PORT_W-1:0] sparse_addr;

  // window is power-of-two sized and aligned: compare upper bits only
  assign hit         = (addr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);
  assign contig_addr = addr[PORT_W-1:0];

  generate
    if (SPARSE_EN) begin : g_sparse
      // page bits land above the in-page port bits
      assign sparse_addr = {addr[SPARSE_HI_LSB +: SPARSE_HI_W], addr[SPARSE_LO_W-1:0]};
    end else begin : g_flat
      assign sparse_addr = contig_addr;
    end
  endgenerate

  assign xaddr = sparse ? sparse_addr : contig_addr;

endmodule

// File: rtl/iowin_ctrl.sv
module iowin_ctrl
  import iowin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_req,
  input  logic hit,
  input  logic port_ack,
  output logic load_en,
  output logic cap_en,
  output logic port_req,
  output logic cpu_ack
);

  iowin_state_e state_q;
  iowin_state_e state_d;

  always_comb begin
    state_d = state_q;
    load_en = 1'b0;
    cap_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req && hit) begin
          load_en = 1'b1;
          state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (port_ack) begin
          cap_en  = 1'b1;
          state_d = ST_RESP;
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign port_req = (state_q == ST_ISSUE);
  assign cpu_ack  = (state_q == ST_RESP);

  AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> !port_req && !cpu_ack); // R1
  AST_HIT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && cpu_req && hit) |=> port_req); // R2
  AST_MISS_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && cpu_req && !hit) |=> !port_req && !cpu_ack); // R3
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack && !port_req); // R8
  AST_ACK_FOLLOWS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> $past(port_req && port_ack)); // R8
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !port_req); // R10

endmodule

// File: rtl/iowin_hold.sv
module iowin_hold #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PORT_W = 16,
  parameter int unsigned SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [PORT_W-1:0] addr_in,
  input  logic              we_in,
  input  logic [SIZE_W-1:0] size_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] rdata_in,
  output logic [PORT_W-1:0] addr_q,
  output logic              we_q,
  output logic [SIZE_W-1:0] size_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);

  logic rd_cap;
  assign rd_cap = cap_en && !we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      size_q  <= '0;
      wdata_q <= '0;
    end else if (load_en) begin
      addr_q  <= addr_in;
      we_q    <= we_in;
      size_q  <= size_in;
      wdata_q <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_cap) rdata_q <= rdata_in;
  end

endmodule

// File: rtl/iowin_xlate.sv
module iowin_xlate
  import iowin_pkg::*;
#(
  parameter int unsigned       ADDR_W        = 32,
  parameter int unsigned       DATA_W        = 32,
  parameter int unsigned       PORT_W        = 16,
  parameter int unsigned       WIN_LOG2      = 23,
  parameter logic [ADDR_W-1:0] WIN_BASE      = 32'h8000_0000,
  parameter int unsigned       SPARSE_LO_W   = 5,
  parameter int unsigned       SPARSE_HI_LSB = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_sparse,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [SIZE_W-1:0] cpu_size,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ack,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              port_req,
  output logic              port_we,
  output logic [SIZE_W-1:0] port_size,
  output logic [PORT_W-1:0] port_addr,
  output logic [DATA_W-1:0] port_wdata,
  input  logic              port_ack,
  input  logic [DATA_W-1:0] port_rdata
);

  logic              win_hit;
  logic [PORT_W-1:0] xaddr;
  logic              load_en;
  logic              cap_en;

  iowin_decode #(
    .ADDR_W(ADDR_W), .PORT_W(PORT_W), .WIN_LOG2(WIN_LOG2), .WIN_BASE(WIN_BASE),
    .SPARSE_LO_W(SPARSE_LO_W), .SPARSE_HI_LSB(SPARSE_HI_LSB), .SPARSE_EN(1'b1)
  ) u_decode (
    .addr  (cpu_addr),
    .sparse(map_sparse),
    .hit   (win_hit),
    .xaddr (xaddr)
  );

  iowin_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_req (cpu_req),
    .hit     (win_hit),
    .port_ack(port_ack),
    .load_en (load_en),
    .cap_en  (cap_en),
    .port_req(port_req),
    .cpu_ack (cpu_ack)
  );

  iowin_hold #(.DATA_W(DATA_W), .PORT_W(PORT_W), .SIZE_W(SIZE_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .addr_in (xaddr),
    .we_in   (cpu_we),
    .size_in (cpu_size),
    .wdata_in(cpu_wdata),
    .cap_en  (cap_en),
    .rdata_in(port_rdata),
    .addr_q  (port_addr),
    .we_q    (port_we),
    .size_q  (port_size),
    .wdata_q (port_wdata),
    .rdata_q (cpu_rdata)
  );

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (port_req && !port_ack) |=> port_req && $stable(port_addr) && $stable(port_size)
                                && $stable(port_we) && $stable(port_wdata)); // R7
  AST_RDATA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !port_we) |-> cpu_rdata == $past(port_rdata)); // R8
  AST_FIELDS_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_req && !cpu_ack && cpu_req && win_hit) |=>
      port_we == $past(cpu_we) && port_size == $past(cpu_size)
      && port_wdata == $past(cpu_wdata)); // R6

endmodule

// File: tb/iowin_xlate_bench.sv
module iowin_xlate_bench;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC       = 9;

  typedef struct packed {
    logic [31:0] addr;
    logic        sparse;
    logic [1:0]  size;
    logic        we;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [15:0] exp;
  } vec_t;

  // addr, mode, size, we, wdata, port read data, expected port address
  localparam vec_t VEC [NVEC] = '{
    '{32'h8000_0000, 1'b0, 2'd0, 1'b0, 32'h0,         32'h0000_00A5, 16'h0000},
    '{32'h8000_03F8, 1'b0, 2'd0, 1'b1, 32'h0000_005A, 32'h0,         16'h03F8},
    '{32'h8000_03F8, 1'b1, 2'd1, 1'b0, 32'h0,         32'h0000_BEEF, 16'h0018},
    '{32'h807F_F01F, 1'b1, 2'd2, 1'b0, 32'h0,         32'h1234_5678, 16'hFFFF},
    '{32'h807F_FFFF, 1'b0, 2'd0, 1'b1, 32'h0000_0011, 32'h0,         16'hFFFF},
    '{32'h8012_3456, 1'b0, 2'd2, 1'b1, 32'hCAFE_F00D, 32'h0,         16'h3456},
    '{32'h8012_3456, 1'b1, 2'd1, 1'b1, 32'h0000_A55A, 32'h0,         16'h2476},
    '{32'h8000_1003, 1'b1, 2'd0, 1'b0, 32'h0,         32'h0000_0077, 16'h0023},
    '{32'h8001_0000, 1'b0, 2'd2, 1'b0, 32'h0,         32'h8765_4321, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_sparse = 1'b0;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [1:0]  cpu_size = 2'd0;
  logic [31:0] cpu_addr = 32'h0;
  logic [31:0] cpu_wdata = 32'h0;
  logic        cpu_ack;
  logic [31:0] cpu_rdata;
  logic        port_req;
  logic        port_we;
  logic [1:0]  port_size;
  logic [15:0] port_addr;
  logic [31:0] port_wdata;
  logic        port_ack = 1'b0;
  logic [31:0] port_rdata = 32'h0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iowin_xlate u_iowin_xlate (
    .clk(clk), .rst_n(rst_n), .map_sparse(map_sparse),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .port_req(port_req), .port_we(port_we), .port_size(port_size),
    .port_addr(port_addr), .port_wdata(port_wdata),
    .port_ack(port_ack), .port_rdata(port_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_access(input vec_t v, input int gap);
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = v.addr; cpu_we = v.we; cpu_size = v.size;
    cpu_wdata = v.wdata; map_sparse = v.sparse;
    @(negedge clk);
    cpu_req = 1'b0;
    chk(port_req == 1'b1, "R2 port_req", {31'd0, port_req}, 32'd1);
    chk(port_addr == v.exp, v.sparse ? "R5 sparse addr" : "R4 contiguous addr",
        {16'd0, port_addr}, {16'd0, v.exp});
    chk(port_size == v.size && port_we == v.we && port_wdata == v.wdata, "R6 fields",
        {port_wdata[28:0], port_we, port_size}, {v.wdata[28:0], v.we, v.size});
    // disturb: flip the mode and strobe another access while busy
    map_sparse = ~v.sparse; cpu_req = 1'b1; cpu_addr = 32'h8000_0FFF;
    cpu_we = ~v.we; cpu_size = 2'd1; cpu_wdata = ~v.wdata;
    @(negedge clk);
    cpu_req = 1'b0;
    for (int k = 0; k < gap; k++) @(negedge clk);
    chk(port_addr == v.exp, "R9 mode change ignored", {16'd0, port_addr}, {16'd0, v.exp});
    chk(port_req && port_size == v.size && port_we == v.we && port_wdata == v.wdata,
        "R7 held fields", {port_wdata[27:0], port_req, port_we, port_size},
        {v.wdata[27:0], 1'b1, v.we, v.size});
    chk(!cpu_ack, "R10 busy strobe no ack", {31'd0, cpu_ack}, 32'd0);
    port_ack = 1'b1; port_rdata = v.rdata;
    @(negedge clk);
    port_ack = 1'b0; port_rdata = 32'hDEAD_BEEF;
    chk(cpu_ack && !port_req, "R8 ack pulse", {30'd0, cpu_ack, port_req}, 32'd2);
    if (!v.we) chk(cpu_rdata == v.rdata, "R8 read data", cpu_rdata, v.rdata);
    @(negedge clk);
    chk(!cpu_ack, "R8 ack one cycle", {31'd0, cpu_ack}, 32'd0);
    chk(!port_req, "R10 no extra cycle", {31'd0, port_req}, 32'd0);
  endtask

  task automatic run_miss(input logic [31:0] a);
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = a; cpu_we = 1'b0; cpu_size = 2'd2;
    @(negedge clk);
    cpu_req = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(!port_req && !cpu_ack, "R3 miss unclaimed", {30'd0, port_req, cpu_ack}, 32'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!port_req && !cpu_ack, "R1 in reset", {30'd0, port_req, cpu_ack}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!port_req && !cpu_ack, "R1 after reset", {30'd0, port_req, cpu_ack}, 32'd0);
    for (int i = 0; i < NVEC; i++) run_access(VEC[i], i % 3);
    run_miss(32'h7FFF_FFFC);
    run_miss(32'h8080_0000);
    run_miss(32'h0000_0092);
    // a hit right after a miss still works
    run_access(VEC[3], 1);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog expired act=%h exp=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule